// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the page-load sequencer of a sector-programmed non-volatile memory. It sees every captured write cycle (a valid strobe with address and data) and looks for short command prefixes that must open a page load. A three-write prefix arms software write protection. A six-write prefix selects one of four commands: protection off, auto-clear off, auto-clear on, or a whole-array clear. Any write that breaks a prefix sends the decoder back to idle. A byte-load timeout in the middle of a prefix does the same.

The decoder tells the sequencer, write by write, whether a byte belongs to the page (`byte_accept`). Prefix writes are never page bytes. The sequencer reports the end of byte loading (`load_timeout`) and the end of the internal timed operation (`cycle_done`). Mode changes stay pending until the program cycle that follows the prefix completes, and they commit only if all page offsets were loaded. The protection and auto-clear flags model fuse storage and are reset only by the power-on reset `rst`.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, protect_on is 0, autoclear_on is 1, clear_start is 0 and load_active is 0.
- R2: With protection off, a write in idle that is not AAh at address 5555h is accepted as a page byte, and load_active is 1 from the next cycle. While load_active is 1, every write is accepted except in a cycle where load_timeout is 1.
- R3: With protection on, a write in idle that does not start a prefix is not accepted, and load_active stays 0.
- R4: The writes AAh@5555h, 55h@2AAAh, A0h@5555h (address on bits 14..0) are not accepted and open a page load. After all offsets 0..PAGE_BYTES-1 (address bits 6..0) are loaded, load_timeout is given and then cycle_done, and protect_on reads 1 from the cycle after cycle_done.
- R5: After AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, a sixth write to 5555h with data 20h, 40h or 50h opens a page load. On a full-page commit, these set protect_on to 0, autoclear_on to 0 and autoclear_on to 1, in that order of codes.
- R6: A sixth write of 10h@5555h raises clear_start for exactly one cycle, the cycle after that write. Until cycle_done, no write is accepted and the flags do not change.
- R7: A prefix write with the wrong address or data returns the decoder to idle. That write is not accepted, and the next write is decoded from idle.
- R8: load_timeout during a prefix returns the decoder to idle.
- R9: If any page offset was not loaded when the program cycle ends, the pending command is dropped and the flags are unchanged.
- R10: After load_timeout ends a page load, load_active is 0 and no write is accepted until cycle_done.
- R11: protect_on and autoclear_on change only in the cycle after a cycle_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_valid | input | 1 | A captured write cycle is present |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data of the write |
| load_timeout | input | 1 | Byte-load window expired |
| cycle_done | input | 1 | Internal timed program or clear operation finished |
| byte_accept | output | 1 | Current write is a page byte (combinational) |
| load_active | output | 1 | A page load is open |
| clear_start | output | 1 | One-cycle request to start a whole-array clear |
| protect_on | output | 1 | Software write protection active |
| autoclear_on | output | 1 | Sector clear before program enabled |

## Verification
The bench drives plain page loads with protection off and on, each of the five command prefixes followed by full pages, and the same prefixes followed by partial pages. A full page separates a committed command from one that is dropped at the end of the cycle. The bench also breaks prefixes at the second and sixth step with a wrong address or an unknown code, and lets a load timeout fall inside a prefix. These cases show whether an abort really returns to idle, or whether a later stray A0h write can still complete protection. Writes issued during the program and clear intervals show whether a busy decoder leaks bytes into the page.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

    localparam int CMD_AW = 15;
    localparam int CMD_DW = 8;

    localparam logic [CMD_AW-1:0] KEY_ADDR_HI = 15'h5555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_LO = 15'h2AAA;
    localparam logic [CMD_DW-1:0] KEY_D1      = 8'hAA;
    localparam logic [CMD_DW-1:0] KEY_D2      = 8'h55;
    localparam logic [CMD_DW-1:0] CODE_LOCK   = 8'hA0;
    localparam logic [CMD_DW-1:0] CODE_EXT    = 8'h80;
    localparam logic [CMD_DW-1:0] CODE_UNLOCK = 8'h20;
    localparam logic [CMD_DW-1:0] CODE_ERASE  = 8'h10;
    localparam logic [CMD_DW-1:0] CODE_ACOFF  = 8'h40;
    localparam logic [CMD_DW-1:0] CODE_ACON   = 8'h50;

    typedef enum logic [3:0] {
        ST_IDLE, ST_K1, ST_K2, ST_X3, ST_X4, ST_X5, ST_LOAD, ST_PROG, ST_ERASE
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_PROT_ON, CMD_PROT_OFF, CMD_AC_OFF, CMD_AC_ON
    } cmd_t;

    typedef struct packed {
        logic              valid;
        logic [CMD_AW-1:0] addr;
        logic [CMD_DW-1:0] data;
    } wr_beat_t;

    function automatic logic beat_is(input wr_beat_t b,
                                     input logic [CMD_AW-1:0] a,
                                     input logic [CMD_DW-1:0] d);
        return b.valid && (b.addr == a) && (b.data == d);
    endfunction

endpackage

// File: rtl/ucd_step_fsm.sv
module ucd_step_fsm
    import ucd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_beat_t   beat,
    input  logic       load_timeout,
    input  logic       cycle_done,
    input  logic       protect_on,
    output seq_state_t state,
    output cmd_t       pend_cmd,
    output logic       accept,
    output logic       erase_go
);

    seq_state_t nxt;
    cmd_t       nxt_cmd;
    logic       erase_nxt;

    always_comb begin
        nxt       = state;
        nxt_cmd   = pend_cmd;
        accept    = 1'b0;
        erase_nxt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (beat.valid) begin
                    if (beat_is(beat, KEY_ADDR_HI, KEY_D1)) begin
                        nxt = ST_K1;
                    end else if (!protect_on) begin
                        accept  = 1'b1;
                        nxt     = ST_LOAD;
                        nxt_cmd = CMD_NONE;
                    end
                end
            end
            ST_K1: begin
                if (load_timeout) nxt = ST_IDLE;
                else if (beat.valid)
                    nxt = beat_is(beat, KEY_ADDR_LO, KEY_D2) ? ST_K2 : ST_IDLE;
            end
            ST_K2: begin
                if (load_timeout) nxt = ST_IDLE;
                else if (beat.valid) begin
                    if (beat_is(beat, KEY_ADDR_HI, CODE_LOCK)) begin
                        nxt     = ST_LOAD;
                        nxt_cmd = CMD_PROT_ON;
                    end else if (beat_is(beat, KEY_ADDR_HI, CODE_EXT)) begin
                        nxt = ST_X3;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            ST_X3: begin
                if (load_timeout) nxt = ST_IDLE;
                else if (beat.valid)
                    nxt = beat_is(beat, KEY_ADDR_HI, KEY_D1) ? ST_X4 : ST_IDLE;
            end
            ST_X4: begin
                if (load_timeout) nxt = ST_IDLE;
                else if (beat.valid)
                    nxt = beat_is(beat, KEY_ADDR_LO, KEY_D2) ? ST_X5 : ST_IDLE;
            end
            ST_X5: begin
                if (load_timeout) nxt = ST_IDLE;
                else if (beat.valid) begin
                    nxt = ST_IDLE;
                    if (beat.addr == KEY_ADDR_HI) begin
                        if (beat.data == CODE_UNLOCK) begin
                            nxt = ST_LOAD; nxt_cmd = CMD_PROT_OFF;
                        end else if (beat.data == CODE_ACOFF) begin
                            nxt = ST_LOAD; nxt_cmd = CMD_AC_OFF;
                        end else if (beat.data == CODE_ACON) begin
                            nxt = ST_LOAD; nxt_cmd = CMD_AC_ON;
                        end else if (beat.data == CODE_ERASE) begin
                            nxt = ST_ERASE; erase_nxt = 1'b1;
                        end
                    end
                end
            end
            ST_LOAD: begin
                if (load_timeout) nxt = ST_PROG;
                else if (beat.valid) accept = 1'b1;
            end
            ST_PROG: begin
                if (cycle_done) begin
                    nxt     = ST_IDLE;
                    nxt_cmd = CMD_NONE;
                end
            end
            ST_ERASE: begin
                if (cycle_done) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            pend_cmd <= CMD_NONE;
            erase_go <= 1'b0;
        end else begin
            state    <= nxt;
            pend_cmd <= nxt_cmd;
            erase_go <= erase_nxt;
        end
    end

endmodule

// File: rtl/ucd_page_track.sv
module ucd_page_track #(
    parameter int PAGE_BYTES = 128,
    localparam int IDX_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             keep,
    output logic             full
);

    logic [PAGE_BYTES-1:0] mask;

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                mask[i] <= 1'b0;
            end else if (set_en) begin
                mask[i] <= (set_idx == IDX_W'(i)) | (keep & mask[i]);
            end else if (!keep) begin
                mask[i] <= 1'b0;
            end
        end
    end

    assign full = &mask;

endmodule

// File: rtl/ucd_mode_flags.sv
module ucd_mode_flags
    import ucd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  cmd_t cmd,
    output logic protect_on,
    output logic autoclear_on
);

    always_ff @(posedge clk) begin
        if (rst) begin
            protect_on   <= 1'b0;
            autoclear_on <= 1'b1;
        end else if (commit) begin
            unique case (cmd)
                CMD_PROT_ON:  protect_on   <= 1'b1;
                CMD_PROT_OFF: protect_on   <= 1'b0;
                CMD_AC_OFF:   autoclear_on <= 1'b0;
                CMD_AC_ON:    autoclear_on <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import ucd_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_timeout,
    input  logic              cycle_done,
    output logic              byte_accept,
    output logic              load_active,
    output logic              clear_start,
    output logic              protect_on,
    output logic              autoclear_on
);

    localparam int IDX_W = $clog2(PAGE_BYTES);

    wr_beat_t   beat;
    seq_state_t state;
    cmd_t       pend_cmd;
    logic       page_full;
    logic       keep_page;
    logic       commit;

    assign beat.valid = wr_valid;
    assign beat.addr  = wr_addr[CMD_AW-1:0];
    assign beat.data  = wr_data[CMD_DW-1:0];

    ucd_step_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .beat         (beat),
        .load_timeout (load_timeout),
        .cycle_done   (cycle_done),
        .protect_on   (protect_on),
        .state        (state),
        .pend_cmd     (pend_cmd),
        .accept       (byte_accept),
        .erase_go     (clear_start)
    );

    assign keep_page = (state == ST_LOAD) || (state == ST_PROG);

    ucd_page_track #(.PAGE_BYTES(PAGE_BYTES)) u_track (
        .clk     (clk),
        .rst     (rst),
        .set_en  (byte_accept),
        .set_idx (wr_addr[IDX_W-1:0]),
        .keep    (keep_page),
        .full    (page_full)
    );

    assign commit = (state == ST_PROG) && cycle_done && page_full;

    ucd_mode_flags u_flags (
        .clk          (clk),
        .rst          (rst),
        .commit       (commit),
        .cmd          (pend_cmd),
        .protect_on   (protect_on),
        .autoclear_on (autoclear_on)
    );

    assign load_active = (state == ST_LOAD);

endmodule

// File: rtl/ucd_checker.sv
module ucd_checker #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              load_timeout,
    input logic              cycle_done,
    input logic              byte_accept,
    input logic              load_active,
    input logic              clear_start,
    input logic              protect_on,
    input logic              autoclear_on
);

    p_clear_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        clear_start |=> !clear_start);

    p_clear_no_accept_r6: assert property (@(posedge clk) disable iff (rst)
        clear_start |-> !byte_accept && !load_active);

    p_flags_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !cycle_done |=> $stable(protect_on) && $stable(autoclear_on));

    p_prog_closed_r10: assert property (@(posedge clk) disable iff (rst)
        (load_active && load_timeout) |=> !load_active && !byte_accept);

    p_prot_reject_r3: assert property (@(posedge clk) disable iff (rst)
        (protect_on && !load_active && wr_valid && wr_addr[14:0] != 15'h5555)
        |-> !byte_accept);

endmodule

bind unlock_seq_decoder ucd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .load_timeout (load_timeout),
    .cycle_done   (cycle_done),
    .byte_accept  (byte_accept),
    .load_active  (load_active),
    .clear_start  (clear_start),
    .protect_on   (protect_on),
    .autoclear_on (autoclear_on)
);

// File: tb/tb_unlock_seq_decoder.sv
module tb_unlock_seq_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_timeout = 1'b0;
    logic        cycle_done = 1'b0;
    logic        byte_accept, load_active, clear_start, protect_on, autoclear_on;

    always #2 clk = ~clk;

    unlock_seq_decoder dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_timeout(load_timeout), .cycle_done(cycle_done),
        .byte_accept(byte_accept), .load_active(load_active),
        .clear_start(clear_start), .protect_on(protect_on),
        .autoclear_on(autoclear_on)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string cur_req = "R1";

    // reference model: 0 idle, 1..5 prefix steps, 6 load, 7 program, 8 clear
    int       ms = 0;
    int       mpend = 0;
    bit [127:0] mmask = '0;
    bit       mprot = 0;
    bit       mac = 1;
    bit       mclr = 0;

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0b exp=%0b", cur_req, what, act, exp);
        end
    endtask

    function automatic bit m_accept(bit v, logic [14:0] a, logic [7:0] d, bit t);
        if (ms == 0) return v && !(a == 15'h5555 && d == 8'hAA) && !mprot;
        if (ms == 6) return v && !t;
        return 0;
    endfunction

    task automatic m_update(bit v, logic [14:0] a, logic [7:0] d, bit t, bit c);
        mclr = 0;
        case (ms)
            0: if (v) begin
                   if (a == 15'h5555 && d == 8'hAA) ms = 1;
                   else if (!mprot) begin
                       ms = 6; mpend = 0; mmask = '0; mmask[a[6:0]] = 1;
                   end
               end
            1: if (t) ms = 0; else if (v) ms = (a == 15'h2AAA && d == 8'h55) ? 2 : 0;
            2: if (t) ms = 0; else if (v) begin
                   if (a == 15'h5555 && d == 8'hA0) begin ms = 6; mpend = 1; mmask = '0; end
                   else if (a == 15'h5555 && d == 8'h80) ms = 3;
                   else ms = 0;
               end
            3: if (t) ms = 0; else if (v) ms = (a == 15'h5555 && d == 8'hAA) ? 4 : 0;
            4: if (t) ms = 0; else if (v) ms = (a == 15'h2AAA && d == 8'h55) ? 5 : 0;
            5: if (t) ms = 0; else if (v) begin
                   ms = 0;
                   if (a == 15'h5555) begin
                       if (d == 8'h20) begin ms = 6; mpend = 2; mmask = '0; end
                       if (d == 8'h40) begin ms = 6; mpend = 3; mmask = '0; end
                       if (d == 8'h50) begin ms = 6; mpend = 4; mmask = '0; end
                       if (d == 8'h10) begin ms = 8; mclr = 1; end
                   end
               end
            6: if (t) ms = 7; else if (v) mmask[a[6:0]] = 1;
            7: if (c) begin
                   if (&mmask) begin
                       if (mpend == 1) mprot = 1;
                       if (mpend == 2) mprot = 0;
                       if (mpend == 3) mac = 0;
                       if (mpend == 4) mac = 1;
                   end
                   ms = 0; mpend = 0;
               end
            8: if (c) ms = 0;
            default: ms = 0;
        endcase
    endtask

    task automatic step(input bit v, input logic [14:0] a, input logic [7:0] d,
                        input bit t, input bit c);
        bit ea;
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_data = d; load_timeout = t; cycle_done = c;
        #1;
        ea = m_accept(v, a, d, t);
        chk("byte_accept", byte_accept, ea);
        @(posedge clk);
        m_update(v, a, d, t, c);
        #1;
        chk("protect_on",   protect_on,   mprot);
        chk("autoclear_on", autoclear_on, mac);
        chk("clear_start",  clear_start,  mclr);
        chk("load_active",  load_active,  ms == 6);
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        step(1, a, d, 0, 0);
    endtask

    task automatic page(input int n);
        for (int i = 0; i < n; i++) wr(15'h0300 + 15'(i), 8'(i * 3));
    endtask

    task automatic end_prog();
        step(0, '0, '0, 1, 0);
        wr(15'h0305, 8'h11);   // ignored while programming (R10)
        step(0, '0, '0, 0, 0);
        step(0, '0, '0, 0, 1);
        step(0, '0, '0, 0, 0);
    endtask

    task automatic pre3(input logic [7:0] code);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, code);
    endtask

    task automatic pre6(input logic [7:0] code);
        pre3(8'h80); wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, code);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        cur_req = "R1";
        chk("reset protect_on",   protect_on,   1'b0);
        chk("reset autoclear_on", autoclear_on, 1'b1);
        chk("reset clear_start",  clear_start,  1'b0);
        chk("reset load_active",  load_active,  1'b0);

        cur_req = "R2"; page(10);
        cur_req = "R10"; end_prog();

        cur_req = "R7"; wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h56); wr(15'h0100, 8'h01);
        cur_req = "R10"; end_prog();

        cur_req = "R4"; pre3(8'hA0); page(128);
        cur_req = "R11"; step(0, '0, '0, 1, 0); step(0, '0, '0, 0, 0);
        cur_req = "R4"; step(0, '0, '0, 0, 1); step(0, '0, '0, 0, 0);
        chk("R4 protection committed", protect_on, 1'b1);

        cur_req = "R3"; wr(15'h0200, 8'h12); wr(15'h0201, 8'h34);
        chk("R3 load stays closed", load_active, 1'b0);

        cur_req = "R7"; wr(15'h5555, 8'hAA); wr(15'h2AAB, 8'h55); wr(15'h5555, 8'hA0);
        wr(15'h0202, 8'h00);
        chk("R7 no load after abort", load_active, 1'b0);
        pre6(8'h33); wr(15'h0203, 8'h00);

        cur_req = "R8"; wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55);
        step(0, '0, '0, 1, 0); wr(15'h5555, 8'hA0);
        chk("R8 timeout aborted", load_active, 1'b0);

        cur_req = "R9"; pre6(8'h20); page(60); end_prog();
        chk("R9 partial keeps protection", protect_on, 1'b1);

        cur_req = "R4"; pre3(8'hA0); page(128); end_prog();
        cur_req = "R5"; pre6(8'h20); page(128); end_prog();
        chk("R5 protection off", protect_on, 1'b0);
        pre6(8'h40); page(128); end_prog();
        chk("R5 autoclear off", autoclear_on, 1'b0);
        pre6(8'h50); page(64); end_prog();
        cur_req = "R9"; chk("R9 partial keeps autoclear off", autoclear_on, 1'b0);
        cur_req = "R5"; pre6(8'h50); page(128); end_prog();
        chk("R5 autoclear on", autoclear_on, 1'b1);

        cur_req = "R6"; pre6(8'h10);
        wr(15'h0100, 8'h77); wr(15'h5555, 8'hAA);
        step(0, '0, '0, 0, 0);
        step(0, '0, '0, 0, 1);
        cur_req = "R2"; wr(15'h0110, 8'h01); page(128); end_prog();

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule